// File: doc/BRIEF.md
# Bridge Header Emulation Shim

This block sits between a host-side configuration access port and a root port whose native configuration header is Type 0. Its BAR slots are aliased onto internal registers. The shim makes the root port look like a compliant Type 1 bridge at bus 0, device 0, function 0.

Registers that a Type 1 header defines but the hardware lacks are served from a local shadow array. The BAR slots are kept away from the hardware the same way. All other bus 0 accesses are redirected to the hardware's own address for its bridge function, which is device 1 on the secondary bus. The header type and class code are patched on the way back.

The shim also vets every address before it reaches the hardware. It keeps track of the secondary bus number and publishes it as the local bus number that the hardware uses to route configuration cycles.

A request is presented for one cycle on the `req_*` inputs. Its response appears on `rsp_*` exactly one cycle later. Forwarded accesses drive the `hw_*` port in the request cycle, and the read data is sampled combinationally in that same cycle.

Top module: `bridge_hdr_shim`

## Requirements
- R1: After reset, `rsp_valid` and `local_bus` are 0. The shadow dword at 0x1C reads 0x0000_0101 (32-bit I/O), the shadow dword at 0x24 reads 0x0001_0001 (64-bit prefetchable), and every other shadow dword reads 0.
- R2: On bus 0, accesses to offsets 0x10–0x33 and 0x38–0x3B use only the shadow array, at dword index (offset − 0x10)/4. They never raise `hw_req`.
- R3: `req_size` is encoded as 0 = byte, 1 = half-word, 2 (or 3) = dword, and accesses are naturally aligned. A write updates only the byte lanes that the size and offset bits 1:0 select, taking the data from the low bits of `req_wdata`. A read returns the selected lanes right-aligned, with the upper bits zero.
- R4: Any write to the shadow dwords at 0x10, 0x14 or 0x38 leaves that dword at zero.
- R5: A shadow write at offset 0x19, or a half-word or dword write at 0x18, sets the secondary bus number to bits 15:8 of the merged dword. `local_bus` shows the new value from the next cycle. A byte write at 0x18 or any write at 0x1A leaves it unchanged.
- R6: On bus 0 only device 0, function 0 is valid. On the bus equal to the secondary bus number only device 0 is valid, with any function. An invalid read returns all ones in the access width (0xFF, 0xFFFF, 0xFFFF_FFFF). An invalid write changes nothing and is not forwarded.
- R7: While `link_up` is 0, accesses to any bus other than 0 are treated as invalid.
- R8: Bus 0 accesses outside the shadow range are forwarded as bus = `local_bus`, device 1, function 0, with the same dword offset. Valid accesses to other buses are forwarded with their own bus, device and function. `hw_be` holds the selected lanes and `hw_wdata` holds the data shifted into those lanes.
- R9: A bus 0 read of the dword at 0x0C returns bits 22:16 as 0x01. All other bits come from the hardware.
- R10: A bus 0 read of the dword at 0x08 returns bits 31:8 as 0x060400. Bits 7:0 come from the hardware.
- R11: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Downstream link is trained |
| req_valid | input | 1 | Configuration request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_bus | input | 8 | Target bus |
| req_dev | input | 5 | Target device |
| req_func | input | 3 | Target function |
| req_off | input | 12 | Byte offset in configuration space |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data, right-aligned |
| hw_req | output | 1 | Forwarded access strobe |
| hw_write | output | 1 | Forwarded access is a write |
| hw_bus | output | 8 | Forwarded bus |
| hw_dev | output | 5 | Forwarded device |
| hw_func | output | 3 | Forwarded function |
| hw_off | output | 12 | Forwarded dword-aligned offset |
| hw_be | output | 4 | Forwarded byte enables |
| hw_wdata | output | 32 | Forwarded lane-aligned write data |
| hw_rdata | input | 32 | Hardware read data for the current forwarded access |
| local_bus | output | 8 | Local bus number pushed to the hardware |

## Verification
The bench writes every byte lane of every shadow dword and reads the results back as dwords and half-words. A design that merged lanes wrongly, indexed the array off by one, or leaked the request onto the hardware port would corrupt neighbouring shadow values or raise the forward count.

It sweeps all 256 device/function pairs on bus 0 and checks whether the secondary bus accepts only device 0. A validity filter that was too loose or too strict would either forward a phantom function or return all ones for the real bridge.

Separate checks cover the write widths that do and do not move the secondary bus number, and the zeroed BAR and ROM slots. The bus 0 remap, the link-down gate, and the header-type and class patches are each checked against a plain access on another bus, so a patch applied in the wrong place also shows up.

// File: rtl/bhs_pkg.sv
package bhs_pkg;

  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int OFF_W  = 12;
  localparam int DW     = 32;
  localparam int BE_W   = DW / 8;

  // Shadow window: two byte ranges on bus 0
  localparam int SH_BASE   = 'h10;
  localparam int SH_A_END  = 'h34;
  localparam int SH_B_BASE = 'h38;
  localparam int SH_B_END  = 'h3C;
  localparam int SH_WORDS  = (SH_B_END - SH_BASE) / 4;
  localparam int SH_IDX_W  = $clog2(SH_WORDS);

  localparam int IDX_BAR0   = 0;
  localparam int IDX_BAR1   = 1;
  localparam int IDX_BUSNUM = 2;
  localparam int IDX_IOWIN  = 3;
  localparam int IDX_PFWIN  = 5;
  localparam int IDX_ROM    = (SH_B_BASE - SH_BASE) / 4;

  localparam logic [DW-1:0] INIT_IOWIN = 32'h0000_0101;
  localparam logic [DW-1:0] INIT_PFWIN = 32'h0001_0001;

  localparam logic [OFF_W-1:0] OFF_SECBUS = 12'h019;
  localparam logic [OFF_W-1:0] OFF_BUSDW  = 12'h018;

  localparam int          DWI_CLASS   = 2;
  localparam int          DWI_HDR     = 3;
  localparam logic [23:0] CLASS_PCI2PCI = 24'h060400;
  localparam logic [6:0]  HDR_KIND_BRG  = 7'h01;
  localparam logic [DEV_W-1:0] BRIDGE_LOCAL_DEV = 5'd1;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
  typedef enum logic [1:0] {RT_DROP = 2'd0, RT_SHADOW = 2'd1, RT_FWD = 2'd2} route_e;

  function automatic logic [BE_W-1:0] lane_mask(logic [1:0] sz, logic [1:0] lo);
    case (sz)
      SZ_BYTE: return BE_W'(1) << lo;
      SZ_HALF: return lo[1] ? 4'b1100 : 4'b0011;
      default: return '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_place(logic [1:0] sz, logic [1:0] lo, logic [DW-1:0] d);
    case (sz)
      SZ_BYTE: return d << {lo, 3'b000};
      SZ_HALF: return d << {lo[1], 4'b0000};
      default: return d;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_pick(logic [1:0] sz, logic [1:0] lo, logic [DW-1:0] d);
    logic [DW-1:0] s;
    case (sz)
      SZ_BYTE: begin s = d >> {lo, 3'b000};    return {24'h0, s[7:0]};  end
      SZ_HALF: begin s = d >> {lo[1], 4'b0000}; return {16'h0, s[15:0]}; end
      default: return d;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                              logic [BE_W-1:0] be);
    logic [DW-1:0] r;
    for (int i = 0; i < BE_W; i++) r[8*i +: 8] = be[i] ? nw[8*i +: 8] : old[8*i +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] shadow_init(int i);
    if (i == IDX_IOWIN) return INIT_IOWIN;
    if (i == IDX_PFWIN) return INIT_PFWIN;
    return '0;
  endfunction

endpackage

// File: rtl/bhs_decode.sv
module bhs_decode
  import bhs_pkg::*;
(
  input  logic              link_up,
  input  logic [1:0]        req_size,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [BUS_W-1:0]  sec_bus,
  output route_e            route,
  output logic [SH_IDX_W-1:0] sh_idx,
  output logic              sec_hit,
  output logic              on_root,
  output logic [BUS_W-1:0]  fwd_bus,
  output logic [DEV_W-1:0]  fwd_dev,
  output logic [FUNC_W-1:0] fwd_func
);

  logic addr_ok;
  logic in_window;

  always_comb begin
    on_root   = (req_bus == '0);
    in_window = ((req_off >= OFF_W'(SH_BASE))   && (req_off < OFF_W'(SH_A_END))) ||
                ((req_off >= OFF_W'(SH_B_BASE)) && (req_off < OFF_W'(SH_B_END)));

    if (on_root)
      addr_ok = (req_dev == '0) && (req_func == '0);
    else
      addr_ok = link_up && !((req_bus == sec_bus) && (req_dev != '0));

    if (!addr_ok)                route = RT_DROP;
    else if (on_root && in_window) route = RT_SHADOW;
    else                         route = RT_FWD;

    sh_idx  = SH_IDX_W'(req_off[5:2] - 4'(SH_BASE / 4));
    sec_hit = (req_off == OFF_SECBUS) ||
              ((req_off == OFF_BUSDW) && (req_size != SZ_BYTE));

    fwd_bus  = on_root ? sec_bus          : req_bus;
    fwd_dev  = on_root ? BRIDGE_LOCAL_DEV : req_dev;
    fwd_func = on_root ? '0               : req_func;
  end

endmodule

// File: rtl/bhs_shadow.sv
module bhs_shadow
  import bhs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                sec_upd,
  input  logic [SH_IDX_W-1:0] idx,
  input  logic [BE_W-1:0]     be,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rd_dword,
  output logic [BUS_W-1:0]    sec_bus
);

  logic [DW-1:0]    mem_q [SH_WORDS];
  logic [BUS_W-1:0] sec_q;
  logic [DW-1:0]    cur;
  logic [DW-1:0]    merged;
  logic             idx_ok;
  logic             wr_ce;
  logic             sec_ce;

  always_comb begin
    idx_ok   = (32'(idx) < SH_WORDS);
    cur      = idx_ok ? mem_q[idx] : '0;
    rd_dword = cur;
    merged   = lane_merge(cur, wdata, be);
    if ((32'(idx) == IDX_BAR0) || (32'(idx) == IDX_BAR1) || (32'(idx) == IDX_ROM))
      merged = '0;
    wr_ce  = wr_en && idx_ok;
    sec_ce = wr_ce && sec_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SH_WORDS; i++) mem_q[i] <= shadow_init(i);
      sec_q <= '0;
    end else begin
      if (wr_ce)  mem_q[idx] <= merged;
      if (sec_ce) sec_q      <= merged[15:8];
    end
  end

  assign sec_bus = sec_q;

  AST_BAR_ROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_q[IDX_BAR0] == '0) && (mem_q[IDX_BAR1] == '0) && (mem_q[IDX_ROM] == '0)); // R4

  AST_SECBUS_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec_q) |-> $past(wr_en && sec_upd)); // R5

endmodule

// File: rtl/bhs_patch.sv
module bhs_patch
  import bhs_pkg::*;
(
  input  logic             on_root,
  input  logic [OFF_W-3:0] dw_sel,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout
);

  always_comb begin
    dout = din;
    if (on_root && (dw_sel == (OFF_W-2)'(DWI_HDR)))
      dout[22:16] = HDR_KIND_BRG;
    if (on_root && (dw_sel == (OFF_W-2)'(DWI_CLASS)))
      dout[31:8] = CLASS_PCI2PCI;
  end

endmodule

// File: rtl/bridge_hdr_shim.sv
module bridge_hdr_shim
  import bhs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              hw_req,
  output logic              hw_write,
  output logic [BUS_W-1:0]  hw_bus,
  output logic [DEV_W-1:0]  hw_dev,
  output logic [FUNC_W-1:0] hw_func,
  output logic [OFF_W-1:0]  hw_off,
  output logic [BE_W-1:0]   hw_be,
  output logic [DW-1:0]     hw_wdata,
  input  logic [DW-1:0]     hw_rdata,
  output logic [BUS_W-1:0]  local_bus
);

  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  route_e              route;
  logic [SH_IDX_W-1:0] sh_idx;
  logic                sec_hit;
  logic                on_root;
  logic [BUS_W-1:0]    sec_bus;
  logic [DW-1:0]       sh_dword;
  logic [DW-1:0]       patched;
  logic [BE_W-1:0]     be;
  logic [DW-1:0]       placed;
  logic [DW-1:0]       src_dword;
  logic [DW-1:0]       rdata_d;
  logic                sh_wr;
  logic                rsp_valid_q;
  logic [DW-1:0]       rsp_rdata_q;
  logic                rd_ce;

  bhs_decode u_dec (
    .link_up (link_up),
    .req_size(req_size),
    .req_bus (req_bus),
    .req_dev (req_dev),
    .req_func(req_func),
    .req_off (req_off),
    .sec_bus (sec_bus),
    .route   (route),
    .sh_idx  (sh_idx),
    .sec_hit (sec_hit),
    .on_root (on_root),
    .fwd_bus (hw_bus),
    .fwd_dev (hw_dev),
    .fwd_func(hw_func)
  );

  always_comb begin
    be     = lane_mask(req_size, req_off[1:0]);
    placed = lane_place(req_size, req_off[1:0], req_wdata);
    sh_wr  = req_valid && req_write && (route == RT_SHADOW);
  end

  bhs_shadow u_sh (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (sh_wr),
    .sec_upd (sec_hit),
    .idx     (sh_idx),
    .be      (be),
    .wdata   (placed),
    .rd_dword(sh_dword),
    .sec_bus (sec_bus)
  );

  bhs_patch u_pat (
    .on_root(on_root),
    .dw_sel (req_off[OFF_W-1:2]),
    .din    (hw_rdata),
    .dout   (patched)
  );

  always_comb begin
    hw_req   = req_valid && (route == RT_FWD);
    hw_write = req_write;
    hw_off   = {req_off[OFF_W-1:2], 2'b00};
    hw_be    = be;
    hw_wdata = placed;
    case (route)
      RT_SHADOW: src_dword = sh_dword;
      RT_FWD:    src_dword = patched;
      default:   src_dword = '1;
    endcase
    rdata_d = lane_pick(req_size, req_off[1:0], src_dword);
    rd_ce   = req_valid && !req_write;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      if (rd_ce) rsp_rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign local_bus = sec_bus;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_valid |=> rsp_valid); // R11
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_valid |=> !rsp_valid); // R11
  AST_WINDOW_LOCAL: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && (req_bus == '0) &&
     (((req_off >= 12'h010) && (req_off < 12'h034)) ||
      ((req_off >= 12'h038) && (req_off < 12'h03C)))) |-> !hw_req); // R2
  AST_LINK_GATE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hw_req && (req_bus != '0)) |-> link_up); // R7
  AST_ROOT_REMAP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hw_req && (req_bus == '0)) |-> ((hw_dev == 5'd1) && (hw_func == '0) && (hw_bus == local_bus))); // R8
  AST_ROOT_FN0_ONLY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hw_req && (req_bus == '0)) |-> ((req_dev == '0) && (req_func == '0))); // R6

endmodule

// File: tb/sim_bridge_hdr_shim.sv
`timescale 1ns/1ps
module sim_bridge_hdr_shim;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_up;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_func;
  logic [11:0] req_off;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        hw_req, hw_write;
  logic [7:0]  hw_bus;
  logic [4:0]  hw_dev;
  logic [2:0]  hw_func;
  logic [11:0] hw_off;
  logic [3:0]  hw_be;
  logic [31:0] hw_wdata;
  logic [31:0] hw_rdata;
  logic [7:0]  local_bus;

  always #4 clk = ~clk;

  bridge_hdr_shim u0 (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_off(req_off), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .hw_req(hw_req), .hw_write(hw_write), .hw_bus(hw_bus), .hw_dev(hw_dev),
    .hw_func(hw_func), .hw_off(hw_off), .hw_be(hw_be), .hw_wdata(hw_wdata),
    .hw_rdata(hw_rdata), .local_bus(local_bus)
  );

  // Downstream configuration space model
  logic [31:0] dmem [16];
  logic        bd_en;
  logic [3:0]  bd_idx;
  logic [31:0] bd_val;
  int          fwd_cnt;
  logic [7:0]  l_bus;
  logic [4:0]  l_dev;
  logic [2:0]  l_func;
  logic [11:0] l_off;
  logic [3:0]  l_be;
  logic [31:0] l_wdata;

  function automatic logic [31:0] dinit(int i);
    return 32'h1000_0000 + 32'(i) * 32'h0101_0101;
  endfunction

  assign hw_rdata = dmem[hw_off[5:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) dmem[i] <= dinit(i);
      fwd_cnt <= 0;
    end else begin
      if (bd_en) dmem[bd_idx] <= bd_val;
      if (hw_req) begin
        fwd_cnt <= fwd_cnt + 1;
        l_bus <= hw_bus; l_dev <= hw_dev; l_func <= hw_func;
        l_off <= hw_off; l_be <= hw_be; l_wdata <= hw_wdata;
        if (hw_write)
          for (int l = 0; l < 4; l++)
            if (hw_be[l]) dmem[hw_off[5:2]][8*l +: 8] <= hw_wdata[8*l +: 8];
      end
    end
  end

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] exp_sh [11];
  logic [7:0]  exp_sec;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [1:0] sz, input logic [7:0] b, input logic [4:0] d,
                     input logic [2:0] f, input logic [11:0] o, input logic [31:0] wd,
                     output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_size = sz; req_bus = b; req_dev = d;
    req_func = f; req_off = o; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    rd = rsp_rdata;
  endtask

  task automatic bd(input logic [3:0] i, input logic [31:0] v);
    @(negedge clk); bd_en = 1; bd_idx = i; bd_val = v;
    @(negedge clk); bd_en = 0;
  endtask

  function automatic logic [31:0] pick(logic [1:0] sz, logic [11:0] o, logic [31:0] d);
    if (sz == 0) return (d >> (8 * o[1:0])) & 32'hFF;
    if (sz == 1) return (d >> (16 * o[1])) & 32'hFFFF;
    return d;
  endfunction

  task automatic model_sh_write(input logic [1:0] sz, input logic [11:0] o, input logic [31:0] wd);
    int idx = (int'(o) - 16) / 4;
    int base = (sz == 0) ? int'(o[1:0]) : (sz == 1) ? int'(o[1]) * 2 : 0;
    for (int l = 0; l < 4; l++) begin
      bit cov = (sz == 0) ? (l == int'(o[1:0])) : (sz == 1) ? ((l / 2) == int'(o[1])) : 1'b1;
      if (cov) exp_sh[idx][8*l +: 8] = 8'(wd >> (8 * (l - base)));
    end
    if (idx == 0 || idx == 1 || idx == 10) exp_sh[idx] = 0;
    if (o == 12'h019 || (o == 12'h018 && sz != 0)) exp_sec = exp_sh[2][15:8];
  endtask

  logic [31:0] rd;
  int c0;

  initial begin
    rst_n = 0; link_up = 1; bd_en = 0; bd_idx = 0; bd_val = 0;
    req_valid = 0; req_write = 0; req_size = 0; req_bus = 0; req_dev = 0;
    req_func = 0; req_off = 0; req_wdata = 0;
    for (int i = 0; i < 11; i++) exp_sh[i] = 0;
    exp_sh[3] = 32'h0000_0101; exp_sh[5] = 32'h0001_0001; exp_sec = 0;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
    chk("R1 local_bus in reset", 32'(local_bus), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 initial shadow contents
    for (int i = 0; i < 11; i++) if (i != 9) begin
      acc(0, 2, 0, 0, 0, 12'(16 + 4 * i), 0, rd);
      chk("R1 shadow init", rd, exp_sh[i]);
    end

    // R2 R3 R4 byte-lane sweep of the shadow array
    c0 = fwd_cnt;
    for (int i = 0; i < 11; i++) if (i != 9)
      for (int l = 0; l < 4; l++) begin
        acc(1, 0, 0, 0, 0, 12'(16 + 4 * i + l), 32'(i * 16 + l + 1), rd);
        model_sh_write(0, 12'(16 + 4 * i + l), 32'(i * 16 + l + 1));
      end
    for (int i = 0; i < 11; i++) if (i != 9) begin
      acc(0, 2, 0, 0, 0, 12'(16 + 4 * i), 0, rd);
      chk("R3 R4 shadow dword after byte writes", rd, exp_sh[i]);
      acc(0, 1, 0, 0, 0, 12'(16 + 4 * i + 2), 0, rd);
      chk("R3 shadow upper half", rd, pick(1, 12'(2), exp_sh[i]));
      acc(0, 0, 0, 0, 0, 12'(16 + 4 * i + 1), 0, rd);
      chk("R3 shadow byte1", rd, pick(0, 12'(1), exp_sh[i]));
    end
    chk("R2 shadow traffic never forwarded", 32'(fwd_cnt), 32'(c0));
    chk("R5 secbus from byte write at 0x19", 32'(local_bus), 32'(exp_sec));

    // R4 BAR/ROM forced to zero, R3 word write elsewhere
    acc(1, 2, 0, 0, 0, 12'h010, 32'hFFFF_FFFF, rd);
    acc(1, 2, 0, 0, 0, 12'h014, 32'hFFFF_FFFF, rd);
    acc(1, 1, 0, 0, 0, 12'h03A, 32'hFFFF, rd);
    acc(0, 2, 0, 0, 0, 12'h010, 0, rd); chk("R4 BAR0 zero", rd, 0);
    acc(0, 2, 0, 0, 0, 12'h014, 0, rd); chk("R4 BAR1 zero", rd, 0);
    acc(0, 2, 0, 0, 0, 12'h038, 0, rd); chk("R4 ROM zero", rd, 0);
    acc(1, 2, 0, 0, 0, 12'h020, 32'hCAFE_F00D, rd);
    acc(0, 2, 0, 0, 0, 12'h020, 0, rd); chk("R3 word write readback", rd, 32'hCAFE_F00D);
    acc(1, 1, 0, 0, 0, 12'h022, 32'h0000_BEEF, rd);
    acc(0, 2, 0, 0, 0, 12'h020, 0, rd); chk("R3 half write merge", rd, 32'hBEEF_F00D);

    // R5 secondary bus tracking
    acc(1, 1, 0, 0, 0, 12'h018, 32'h0000_0500, rd);
    chk("R5 half write at 0x18", 32'(local_bus), 5);
    acc(1, 0, 0, 0, 0, 12'h018, 32'h77, rd);
    chk("R5 byte write at 0x18 ignored", 32'(local_bus), 5);
    acc(1, 1, 0, 0, 0, 12'h01A, 32'h0000_4444, rd);
    chk("R5 write at 0x1A ignored", 32'(local_bus), 5);
    acc(1, 0, 0, 0, 0, 12'h019, 32'h09, rd);
    chk("R5 byte write at 0x19", 32'(local_bus), 9);
    acc(1, 2, 0, 0, 0, 12'h018, 32'h0000_0300, rd);
    chk("R5 word write at 0x18", 32'(local_bus), 3);

    // R6 validity sweep on bus 0
    for (int d = 0; d < 32; d++)
      for (int f = 0; f < 8; f++) begin
        c0 = fwd_cnt;
        acc(0, 2, 0, 5'(d), 3'(f), 12'h000, 0, rd);
        if (d == 0 && f == 0) chk("R6 bus0 dev0 fn0 forwarded", rd, dinit(0));
        else begin
          chk("R6 bus0 phantom reads ones", rd, 32'hFFFF_FFFF);
          chk("R6 bus0 phantom not forwarded", 32'(fwd_cnt), 32'(c0));
        end
      end
    acc(0, 0, 0, 2, 0, 12'h001, 0, rd); chk("R6 invalid byte read", rd, 32'hFF);
    acc(0, 1, 0, 0, 4, 12'h002, 0, rd); chk("R6 invalid half read", rd, 32'hFFFF);
    acc(1, 2, 0, 1, 0, 12'h020, 32'h1234_5678, rd);
    acc(0, 2, 0, 0, 0, 12'h020, 0, rd); chk("R6 invalid write no effect", rd, 32'hBEEF_F00D);
    c0 = fwd_cnt;
    acc(0, 2, 3, 1, 0, 12'h000, 0, rd);
    chk("R6 secbus dev1 reads ones", rd, 32'hFFFF_FFFF);
    chk("R6 secbus dev1 not forwarded", 32'(fwd_cnt), 32'(c0));
    acc(0, 2, 3, 0, 2, 12'h004, 0, rd);
    chk("R6 secbus dev0 fn2 valid", rd, dinit(1));

    // R8 forwarding and remap
    acc(0, 2, 0, 0, 0, 12'h004, 0, rd);
    chk("R8 root remap bus", 32'(l_bus), 3);
    chk("R8 root remap dev", 32'(l_dev), 1);
    chk("R8 root remap func", 32'(l_func), 0);
    chk("R8 root remap offset", 32'(l_off), 32'h004);
    acc(1, 0, 0, 0, 0, 12'h03D, 32'h5A, rd);
    chk("R8 forwarded byte enables", 32'(l_be), 32'b0010);
    chk("R8 forwarded lane data", l_wdata & 32'h0000_FF00, 32'h0000_5A00);
    acc(0, 0, 0, 0, 0, 12'h03D, 0, rd);
    chk("R8 R3 forwarded byte readback", rd, 32'h5A);
    acc(0, 2, 7, 4, 1, 12'h02C, 0, rd);
    chk("R8 other bus keeps bus", 32'(l_bus), 7);
    chk("R8 other bus keeps dev", 32'(l_dev), 4);
    chk("R8 other bus keeps func", 32'(l_func), 1);
    chk("R8 other bus data", rd, dinit(11));

    // R7 link gate
    link_up = 0;
    c0 = fwd_cnt;
    acc(0, 2, 3, 0, 0, 12'h000, 0, rd); chk("R7 link down secbus read", rd, 32'hFFFF_FFFF);
    acc(0, 2, 7, 4, 1, 12'h000, 0, rd); chk("R7 link down far bus read", rd, 32'hFFFF_FFFF);
    acc(1, 2, 7, 4, 1, 12'h000, 32'h1, rd);
    chk("R7 link down nothing forwarded", 32'(fwd_cnt), 32'(c0));
    acc(0, 2, 0, 0, 0, 12'h000, 0, rd); chk("R7 bus0 unaffected by link", rd, dinit(0));
    link_up = 1;

    // R9 header type patch
    bd(3, 32'h00FF_1234);
    acc(0, 2, 0, 0, 0, 12'h00C, 0, rd);
    chk("R9 header dword patched", rd, (32'h00FF_1234 & ~32'h007F_0000) | 32'h0001_0000);
    acc(0, 0, 0, 0, 0, 12'h00E, 0, rd); chk("R9 header byte patched", rd, 32'h81);
    acc(0, 2, 3, 0, 0, 12'h00C, 0, rd); chk("R9 no patch off bus 0", rd, 32'h00FF_1234);

    // R10 class code patch
    bd(2, 32'h0580_0011);
    acc(0, 2, 0, 0, 0, 12'h008, 0, rd);
    chk("R10 class dword", rd, (32'h0604_00 << 8) | 32'h11);
    acc(0, 0, 0, 0, 0, 12'h00B, 0, rd); chk("R10 class byte", rd, 32'h06);
    acc(0, 2, 3, 0, 0, 12'h008, 0, rd); chk("R10 no patch off bus 0", rd, 32'h0580_0011);

    // R11 response timing
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = 2; req_bus = 0; req_dev = 0; req_func = 0; req_off = 12'h1C;
    chk("R11 no response in request cycle", 32'(rsp_valid), 0);
    @(negedge clk); req_valid = 0;
    chk("R11 response next cycle", 32'(rsp_valid), 1);
    @(negedge clk);
    chk("R11 response one cycle only", 32'(rsp_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R11 watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule